// File: doc/BRIEF.md
# Cascadable Bidirectional Display Line Loader

This block fills the data register for one display line, one group of six 8-bit gray values per shift-clock edge. Each edge of the shift clock reaches the block as a single-cycle strobe, `px_valid`, on the system clock `clk`, with the 48-bit word on `px_data`. A start pulse on the start pin arms a load. The capture pointer then walks the channel groups either from the first channel to the last or the other way round, and the two polarity-inversion controls can flip either half of each word before it is stored.

When the final group is captured, the block falls back into standby and ignores every further edge until it sees a new start pulse. During the last transfer it drives a one-transfer-wide pulse on its carry pin, so the next device in a cascade starts on the following edge with no gap. In dual-edge mode, successive strobes are taken as alternating rising and falling edges. A phase toggle steers each capture into one of two staging registers, and the two are merged onto a single write path, so no flop needs both clock edges. There is no back-pressure: every strobe is one edge and is consumed at once, so the block has no ready output.

Top module: `cll_top`

## Requirements
- R1: After synchronous reset the block is in standby: `line_done` = 0, `carry_a` = `carry_b` = 0, and every bit of `line_q` is 0.
- R2: When `dir_fwd` = 1, only `start_a` acts as the start input; when `dir_fwd` = 0, only `start_b` does. The other start pin has no effect. A strobe that carries a start captures no data, and the first group is captured on the next strobe.
- R3: With forward order (`dir_fwd` = 1 at the start strobe), dot d (bits 8d+7..8d of `px_data`, bit 0 LSB) of the k-th captured word lands in channel 6k+d. Channel c occupies `line_q` bits 8c+7..8c. The register is updated on the clock after the capture strobe.
- R4: With reverse order (`dir_fwd` = 0 at the start strobe), dot d of the k-th captured word lands in channel CHANNELS-1-(6k+d).
- R5: `inv_lo` = 1 inverts dots 0..2 (bits 0..23) bitwise before storage, and `inv_hi` = 1 inverts dots 3..5 (bits 24..47). Each control leaves the other half untouched.
- R6: After CHANNELS/6 captures the block enters standby. `line_done` goes to 1 on the clock after the last capture, and further strobes without a start leave `line_q` unchanged.
- R7: The carry pin (`carry_b` in forward order, `carry_a` in reverse) goes high after the next-to-last capture strobe and drops after the last capture strobe. The other carry pin stays 0.
- R8: With `dual_edge` = 1, strobes alternate between rising and falling phase. A start may fall on either phase, and the stored line matches what single-edge mode would store.
- R9: A start during a load or in standby restarts filling from the first group, and `line_done` reads 0 on the clock after the start strobe.
- R10: Cycles with `px_valid` = 0 are not edges. They move neither the pointer, nor the phase, nor the carry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| px_valid | input | 1 | One shift-clock edge occurs this cycle |
| px_data | input | 48 | Six 8-bit gray values, dot 0 in the low byte |
| start_a | input | 1 | Start input in forward order |
| start_b | input | 1 | Start input in reverse order |
| dir_fwd | input | 1 | 1 = first-to-last fill order, 0 = last-to-first |
| dual_edge | input | 1 | 1 = strobes alternate rising/falling phase |
| inv_lo | input | 1 | Invert dots 0..2 |
| inv_hi | input | 1 | Invert dots 3..5 |
| carry_a | output | 1 | Start pulse to next stage in reverse order |
| carry_b | output | 1 | Start pulse to next stage in forward order |
| line_q | output | CHANNELS*8 | Filled line register, channel c at bits 8c+7..8c |
| line_done | output | 1 | Line complete, block in standby |

## Verification
The bench builds the block with CHANNELS = 18, which gives three groups per line. That is small enough to compare every channel of every line against arithmetically generated values for every combination of edge mode, fill order and the four inversion settings. With only three groups, the carry pulse, the next-to-last and last captures, and the fall into standby all arrive within a few strobes, so each line exercises them. Idle cycles between strobes, an extra standby strobe before some starts (which moves the start onto the falling phase in dual-edge mode), and a restart partway through a line cover the remaining ordering cases.

// File: rtl/cll_pkg.sv
package cll_pkg;
  typedef enum logic { PH_RISE = 1'b0, PH_FALL = 1'b1 } phase_e;
  typedef enum logic { ST_IDLE = 1'b0, ST_LOAD = 1'b1 } seq_state_e;
endpackage

// File: rtl/cll_seq.sv
module cll_seq
  import cll_pkg::*;
#(
  parameter int GROUPS = 67,
  localparam int PW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          px_valid,
  input  logic          start_a,
  input  logic          start_b,
  input  logic          dir_fwd,
  input  logic          dual_edge,
  output logic          cap_en,
  output logic [PW-1:0] cap_ptr,
  output phase_e        cap_phase,
  output logic          restart,
  output logic          fwd_q,
  output logic          loading,
  output logic          carry_a,
  output logic          carry_b
);
  seq_state_e    state_q;
  logic [PW-1:0] ptr_q;
  phase_e        phase_q;
  logic          carry_q;
  logic          start_sel;
  logic          at_last;
  logic          at_penult;

  always_comb begin
    start_sel = dir_fwd ? start_a : start_b;
    restart   = px_valid && start_sel;
    cap_en    = px_valid && !start_sel && (state_q == ST_LOAD);
    at_last   = (ptr_q == PW'(GROUPS - 1));
    at_penult = (GROUPS >= 2) && (ptr_q == PW'(GROUPS - 2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      phase_q <= PH_RISE;
      fwd_q   <= 1'b1;
      carry_q <= 1'b0;
    end else if (px_valid) begin
      if (dual_edge) phase_q <= (phase_q == PH_RISE) ? PH_FALL : PH_RISE;
      else           phase_q <= PH_RISE;
      if (start_sel) begin
        state_q <= ST_LOAD;
        ptr_q   <= '0;
        fwd_q   <= dir_fwd;
        carry_q <= (GROUPS == 2);
      end else if (state_q == ST_LOAD) begin
        carry_q <= at_penult;
        if (at_last) begin
          state_q <= ST_IDLE;
          ptr_q   <= '0;
        end else begin
          ptr_q <= ptr_q + PW'(1);
        end
      end else begin
        carry_q <= 1'b0;
      end
    end
  end

  assign cap_ptr   = ptr_q;
  assign cap_phase = phase_q;
  assign loading   = (state_q == ST_LOAD);
  assign carry_a   = carry_q && !dir_fwd;
  assign carry_b   = carry_q && dir_fwd;

  // R7
  carry_single_chk: assert property (@(posedge clk) disable iff (rst)
    (carry_q && cap_en) |=> !carry_q);

  // R6
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PW'(GROUPS - 1));

  // R8
  phase_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (px_valid && dual_edge) |=> (phase_q != $past(phase_q)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !px_valid |=> ($stable(ptr_q) && $stable(phase_q) && $stable(carry_q)));
endmodule

// File: rtl/cll_stage.sv
module cll_stage
  import cll_pkg::*;
#(
  parameter int DOT_W  = 8,
  parameter int DOTS   = 6,
  parameter int GROUPS = 67,
  localparam int GW = DOT_W * DOTS,
  localparam int PW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [PW-1:0] cap_ptr,
  input  phase_e        cap_phase,
  input  logic          fwd,
  input  logic          inv_lo,
  input  logic          inv_hi,
  input  logic [GW-1:0] px_data,
  output logic          wr_v,
  output logic [PW-1:0] wr_grp,
  output logic [GW-1:0] wr_word,
  output logic          wr_last
);
  logic [GW-1:0] cond;
  logic [GW-1:0] placed;
  logic [PW-1:0] tgt_grp;
  logic          tgt_last;

  for (genvar d = 0; d < DOTS; d++) begin : g_dot
    localparam bit LOW_HALF = (d < DOTS / 2);
    assign cond[d*DOT_W +: DOT_W] =
      px_data[d*DOT_W +: DOT_W] ^ {DOT_W{LOW_HALF ? inv_lo : inv_hi}};
    assign placed[d*DOT_W +: DOT_W] =
      fwd ? cond[d*DOT_W +: DOT_W] : cond[(DOTS-1-d)*DOT_W +: DOT_W];
  end

  assign tgt_grp  = fwd ? cap_ptr : (PW'(GROUPS - 1) - cap_ptr);
  assign tgt_last = (cap_ptr == PW'(GROUPS - 1));

  logic [GW-1:0] stg_word [2];
  logic [PW-1:0] stg_grp  [2];
  logic          stg_last [2];

  for (genvar p = 0; p < 2; p++) begin : g_phase
    localparam phase_e MY_PH = (p == 0) ? PH_RISE : PH_FALL;
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_word[p] <= '0;
        stg_grp[p]  <= '0;
        stg_last[p] <= 1'b0;
      end else if (cap_en && (cap_phase == MY_PH)) begin
        stg_word[p] <= placed;
        stg_grp[p]  <= tgt_grp;
        stg_last[p] <= tgt_last;
      end
    end
  end

  logic mrg_sel;
  logic wr_v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mrg_sel <= 1'b0;
      wr_v_q  <= 1'b0;
    end else begin
      wr_v_q <= cap_en;
      if (cap_en) mrg_sel <= (cap_phase == PH_FALL);
    end
  end

  assign wr_v    = wr_v_q;
  assign wr_word = stg_word[mrg_sel];
  assign wr_grp  = stg_grp[mrg_sel];
  assign wr_last = stg_last[mrg_sel];

  // R5
  plain_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && fwd && !inv_lo && !inv_hi) |=> (wr_word == $past(px_data)));

  // R3
  fwd_group_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && fwd) |=> (wr_v && wr_grp == $past(cap_ptr)));
endmodule

// File: rtl/cll_line.sv
module cll_line #(
  parameter int DOT_W  = 8,
  parameter int DOTS   = 6,
  parameter int GROUPS = 67,
  localparam int GW = DOT_W * DOTS,
  localparam int LW = GW * GROUPS,
  localparam int PW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_v,
  input  logic [PW-1:0] wr_grp,
  input  logic [GW-1:0] wr_word,
  input  logic          wr_last,
  input  logic          restart,
  output logic [LW-1:0] line_q,
  output logic          done
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [GW-1:0] grp_q;
    always_ff @(posedge clk) begin
      if (rst)                                grp_q <= '0;
      else if (wr_v && (wr_grp == PW'(g)))    grp_q <= wr_word;
    end
    assign line_q[g*GW +: GW] = grp_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                    done <= 1'b0;
    else if (restart)           done <= 1'b0;
    else if (wr_v && wr_last)   done <= 1'b1;
  end

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_v |=> $stable(line_q));

  // R9
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !done);
endmodule

// File: rtl/cll_top.sv
module cll_top #(
  parameter int CHANNELS = 402,
  parameter int DOT_W    = 8,
  parameter int DOTS     = 6,
  localparam int GROUPS = CHANNELS / DOTS,
  localparam int GW     = DOT_W * DOTS,
  localparam int LW     = CHANNELS * DOT_W,
  localparam int PW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          px_valid,
  input  logic [GW-1:0] px_data,
  input  logic          start_a,
  input  logic          start_b,
  input  logic          dir_fwd,
  input  logic          dual_edge,
  input  logic          inv_lo,
  input  logic          inv_hi,
  output logic          carry_a,
  output logic          carry_b,
  output logic [LW-1:0] line_q,
  output logic          line_done
);
  logic            cap_en;
  logic [PW-1:0]   cap_ptr;
  cll_pkg::phase_e cap_phase;
  logic            restart;
  logic            fwd_q;
  logic            loading;
  logic            wr_v;
  logic [PW-1:0]   wr_grp;
  logic [GW-1:0]   wr_word;
  logic            wr_last;

  cll_seq #(.GROUPS(GROUPS)) seq_i (
    .clk(clk), .rst(rst), .px_valid(px_valid),
    .start_a(start_a), .start_b(start_b),
    .dir_fwd(dir_fwd), .dual_edge(dual_edge),
    .cap_en(cap_en), .cap_ptr(cap_ptr), .cap_phase(cap_phase),
    .restart(restart), .fwd_q(fwd_q), .loading(loading),
    .carry_a(carry_a), .carry_b(carry_b)
  );

  cll_stage #(.DOT_W(DOT_W), .DOTS(DOTS), .GROUPS(GROUPS)) stage_i (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_ptr(cap_ptr),
    .cap_phase(cap_phase), .fwd(fwd_q), .inv_lo(inv_lo), .inv_hi(inv_hi),
    .px_data(px_data), .wr_v(wr_v), .wr_grp(wr_grp),
    .wr_word(wr_word), .wr_last(wr_last)
  );

  cll_line #(.DOT_W(DOT_W), .DOTS(DOTS), .GROUPS(GROUPS)) line_i (
    .clk(clk), .rst(rst), .wr_v(wr_v), .wr_grp(wr_grp),
    .wr_word(wr_word), .wr_last(wr_last), .restart(restart),
    .line_q(line_q), .done(line_done)
  );

  // R7
  carry_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(carry_a && carry_b));

  // R6
  done_standby_chk: assert property (@(posedge clk) disable iff (rst)
    line_done |-> !loading);
endmodule

// File: tb/cll_top_tb_top.sv
`timescale 1ns/1ps
module cll_top_tb_top;
  localparam int C  = 18;
  localparam int G  = C / 6;
  localparam int LW = C * 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          px_valid;
  logic [47:0]   px_data;
  logic          start_a, start_b, dir_fwd, dual_edge, inv_lo, inv_hi;
  logic          carry_a, carry_b;
  logic [LW-1:0] line_q;
  logic          line_done;

  int nvec = 0;
  int nbad = 0;
  logic [LW-1:0] exp_line;

  always #4 clk = ~clk;

  cll_top #(.CHANNELS(C)) dut_i (
    .clk(clk), .rst(rst), .px_valid(px_valid), .px_data(px_data),
    .start_a(start_a), .start_b(start_b), .dir_fwd(dir_fwd),
    .dual_edge(dual_edge), .inv_lo(inv_lo), .inv_hi(inv_hi),
    .carry_a(carry_a), .carry_b(carry_b), .line_q(line_q),
    .line_done(line_done)
  );

  function automatic logic [7:0] pat(int ln, int k, int d);
    return 8'((ln * 37 + k * 11 + d * 5 + 3) & 255);
  endfunction

  task automatic chk(string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    px_valid = 1'b0;
    start_a  = 1'b0;
    start_b  = 1'b0;
  endtask

  // drives one strobe; the unselected start pin is held high (R2)
  task automatic beat(logic [47:0] d, logic st, logic do_chk, logic expc);
    @(negedge clk);
    if (do_chk) begin
      chk("R7 carry pin", LW'(dir_fwd ? carry_b : carry_a), LW'(expc));
      chk("R7 other carry pin", LW'(dir_fwd ? carry_a : carry_b), '0);
    end
    px_valid = 1'b1;
    px_data  = d;
    if (dir_fwd) begin start_a = st; start_b = 1'b1; end
    else         begin start_b = st; start_a = 1'b1; end
  endtask

  task automatic run_line(int ln, logic fwd, logic dual, logic ilo, logic ihi, int pre);
    string tag;
    logic [47:0] w;
    tag = {fwd ? "R3" : "R4", (ilo || ihi) ? " R5" : "", dual ? " R8" : "", " R2 R10"};
    @(negedge clk);
    px_valid = 1'b0;
    dir_fwd = fwd; dual_edge = dual; inv_lo = ilo; inv_hi = ihi;
    for (int i = 0; i < pre; i++) beat(48'h5a5a_a5a5_1234, 1'b0, 1'b0, 1'b0);
    beat(48'hdead_beef_cafe, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < G; k++) begin
      if ((k + ln) % 3 == 0) idle();
      for (int d = 0; d < 6; d++) begin
        logic [7:0] v;
        int ch;
        v = pat(ln, k, d);
        w[d*8 +: 8] = v;
        v = v ^ {8{(d < 3) ? ilo : ihi}};
        ch = fwd ? (6 * k + d) : (C - 1 - (6 * k + d));
        exp_line[ch*8 +: 8] = v;
      end
      beat(w, 1'b0, 1'b1, (k == G - 1));
    end
    idle();
    chk("R7 carry after last", LW'({carry_a, carry_b}), '0);
    idle();
    for (int c = 0; c < C; c++)
      chk($sformatf("%s line %0d ch %0d", tag, ln, c),
          LW'(line_q[c*8 +: 8]), LW'(exp_line[c*8 +: 8]));
    chk("R6 done", LW'(line_done), LW'(1'b1));
    beat(~w, 1'b0, 1'b0, 1'b0);
    beat(w ^ 48'h0f0f_0f0f_0f0f, 1'b0, 1'b0, 1'b0);
    idle();
    idle();
    chk($sformatf("R6 standby hold line %0d", ln), line_q, exp_line);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst = 1'b1; px_valid = 1'b0; px_data = '0;
    start_a = 1'b0; start_b = 1'b0; dir_fwd = 1'b1;
    dual_edge = 1'b0; inv_lo = 1'b0; inv_hi = 1'b0;
    exp_line = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 line cleared", line_q, '0);
    chk("R1 done low", LW'(line_done), '0);
    chk("R1 carries low", LW'({carry_a, carry_b}), '0);

    begin
      int ln;
      ln = 0;
      for (int du = 0; du < 2; du++)
        for (int fw = 0; fw < 2; fw++)
          for (int iv = 0; iv < 4; iv++) begin
            run_line(ln, fw[0], du[0], iv[0], iv[1], ln % 2);
            ln++;
          end
    end

    // R9: restart clears done, then a restart partway through a line
    @(negedge clk);
    dir_fwd = 1'b1; dual_edge = 1'b0; inv_lo = 1'b0; inv_hi = 1'b0;
    beat(48'h0, 1'b1, 1'b0, 1'b0);
    idle();
    chk("R9 done cleared by start", LW'(line_done), '0);
    beat(48'hffff_ffff_ffff, 1'b0, 1'b0, 1'b0);
    run_line(99, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    // R9 partway restart in reverse, dual-edge
    @(negedge clk);
    dir_fwd = 1'b0; dual_edge = 1'b1;
    beat(48'h0, 1'b1, 1'b0, 1'b0);
    beat(48'h1111_2222_3333, 1'b0, 1'b0, 1'b0);
    beat(48'h4444_5555_6666, 1'b0, 1'b0, 1'b0);
    run_line(100, 1'b0, 1'b1, 1'b1, 1'b0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule